// File: doc/BRIEF.md
# Logical Unit With Byte Zap

This block is the Boolean datapath of an integer execution pipe. It takes two 64-bit operands and a 7-bit function code, and returns a 64-bit result in the same cycle. Operand B may come from a register or from an immediate. The unit offers three two-operand Boolean operations: AND, OR and XOR. Each of them also has a form that uses the bitwise complement of B.

The unit also has a byte-zap operation. It treats A as eight byte lanes. Each of the low eight bits of B decides whether the matching lane of A passes through or is forced to zero. There are two zap codes with opposite polarity. Any function code the unit does not recognise raises an illegal-function flag and gives an all-zero result.

The block holds no state. The surrounding pipeline registers its inputs and outputs.

Top module: `lzu_unit`

## Requirements
- R1: Function code 0x00 gives result = A AND B.
- R2: Function code 0x08 gives result = A AND (NOT B).
- R3: Function code 0x20 gives A OR B, and code 0x28 gives A OR (NOT B).
- R4: Function code 0x40 gives A XOR B, and code 0x48 gives A XOR (NOT B).
- R5: Function code 0x30 keeps byte lane i of A (bits 8i+7:8i, i = 0..7) when bit i of B is 1. It forces that lane to zero when bit i of B is 0.
- R6: Function code 0x31 forces byte lane i of A to zero when bit i of B is 1. It keeps the lane when bit i of B is 0.
- R7: For both zap codes, bits 63:8 of B have no effect on the result.
- R8: Any function code other than the eight listed above sets illegal_o to 1 and drives the result to zero. Every listed code drives illegal_o to 0.
- R9: Result and flag follow their inputs combinationally. They settle within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B (register value or immediate) |
| func_i | input | 7 | Function code |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | High when the function code is not recognised |

## Verification
The bench checks the zap masks with patterns whose B bits alternate, and with all-ones and all-zeros masks. A unit with swapped zap polarity, or with lanes indexed in reverse order, would clear the wrong bytes. For the zap codes the bench also loads random data into the upper bits of B. A mask built from the wrong bits of B would then change the result. The bench sweeps all 128 function codes, so that any code wrongly decoded as legal, or a stale non-zero result on an illegal code, is reported. Changing the inputs between clock edges catches a design that registered its output.

// File: rtl/lzu_pkg.sv
package lzu_pkg;
  localparam int FUNC_W = 7;

  typedef enum logic [FUNC_W-1:0] {
    FN_AND   = 7'h00,
    FN_ANDN  = 7'h08,
    FN_OR    = 7'h20,
    FN_ORN   = 7'h28,
    FN_ZKEEP = 7'h30,
    FN_ZCLR  = 7'h31,
    FN_XOR   = 7'h40,
    FN_XNOR  = 7'h48
  } lzu_fn_e;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2,
    OP_ZAP = 2'd3
  } lzu_op_e;

  typedef struct packed {
    lzu_op_e op;
    logic    inv_b;
    logic    clr_on_one;
    logic    legal;
  } lzu_ctrl_t;
endpackage

// File: rtl/lzu_decode.sv
module lzu_decode
  import lzu_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output lzu_ctrl_t         ctrl_o
);
  always_comb begin
    ctrl_o = '{op: OP_AND, inv_b: 1'b0, clr_on_one: 1'b0, legal: 1'b1};
    case (func_i)
      FN_AND:   ctrl_o.op = OP_AND;
      FN_ANDN:  begin ctrl_o.op = OP_AND; ctrl_o.inv_b = 1'b1; end
      FN_OR:    ctrl_o.op = OP_OR;
      FN_ORN:   begin ctrl_o.op = OP_OR;  ctrl_o.inv_b = 1'b1; end
      FN_XOR:   ctrl_o.op = OP_XOR;
      FN_XNOR:  begin ctrl_o.op = OP_XOR; ctrl_o.inv_b = 1'b1; end
      FN_ZKEEP: ctrl_o.op = OP_ZAP;
      FN_ZCLR:  begin ctrl_o.op = OP_ZAP; ctrl_o.clr_on_one = 1'b1; end
      default:  ctrl_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lzu_bool.sv
module lzu_bool
  import lzu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lzu_op_e           op_i,
  input  logic              inv_b_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] b_eff;

  assign b_eff = inv_b_i ? ~b_i : b_i;

  always_comb begin
    case (op_i)
      OP_AND:  y_o = a_i & b_eff;
      OP_OR:   y_o = a_i | b_eff;
      OP_XOR:  y_o = a_i ^ b_eff;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/lzu_zap.sv
module lzu_zap #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W/LANE_W-1:0] sel_i,
  input  logic                     clr_on_one_i,
  output logic [DATA_W-1:0]        y_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic keep;
    // polarity: keep when sel differs from the clear level
    assign keep = sel_i[g] ^ clr_on_one_i;
    assign y_o[g*LANE_W +: LANE_W] = keep ? a_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/lzu_unit.sv
module lzu_unit
  import lzu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  lzu_ctrl_t         ctrl;
  logic [DATA_W-1:0] bool_y;
  logic [DATA_W-1:0] zap_y;

  lzu_decode u_decode (
    .func_i (func_i),
    .ctrl_o (ctrl)
  );

  lzu_bool #(.DATA_W(DATA_W)) u_bool (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (ctrl.op),
    .inv_b_i (ctrl.inv_b),
    .y_o     (bool_y)
  );

  lzu_zap #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_zap (
    .a_i          (a_i),
    .sel_i        (b_i[NUM_LANES-1:0]),
    .clr_on_one_i (ctrl.clr_on_one),
    .y_o          (zap_y)
  );

  always_comb begin
    if (!ctrl.legal)          result_o = '0;
    else if (ctrl.op == OP_ZAP) result_o = zap_y;
    else                      result_o = bool_y;
  end

  assign illegal_o = ~ctrl.legal;
endmodule

// File: rtl/lzu_unit_chk.sv
module lzu_unit_chk #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [6:0]        func_i,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  always_comb begin
    if (!$isunknown({func_i, a_i, b_i})) begin
      if (illegal_o)
        AST_ILLEGAL_ZERO: assert (result_o == '0); // R8
      if (func_i == 7'h00)
        AST_AND_SUBSET: assert (((result_o & ~a_i) == '0) && ((result_o & ~b_i) == '0)); // R1
      if (func_i == 7'h08)
        AST_ANDN_DISJOINT: assert ((result_o & b_i) == '0); // R2
      if (func_i == 7'h20)
        AST_OR_COVERS: assert (((result_o & a_i) == a_i) && ((result_o & b_i) == b_i)); // R3
      if (func_i == 7'h48)
        AST_XNOR_PARITY: assert ((result_o ^ a_i ^ b_i) == '1); // R4
      if (func_i == 7'h30 || func_i == 7'h31) begin
        AST_ZAP_SUBSET: assert ((result_o & ~a_i) == '0); // R5
        for (int i = 0; i < NUM_LANES; i++) begin
          if (b_i[i] == (func_i == 7'h31))
            AST_ZAP_CLEARED: assert (result_o[i*LANE_W +: LANE_W] == '0); // R6
          else
            AST_ZAP_KEPT: assert (result_o[i*LANE_W +: LANE_W] == a_i[i*LANE_W +: LANE_W]); // R5
        end
      end
    end
  end
endmodule

bind lzu_unit lzu_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .func_i    (func_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/lzu_unit_bench.sv
`timescale 1ns/1ps
module lzu_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a, b, res;
  logic [6:0]  fn;
  logic        ill;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  lzu_unit u_lzu_unit (
    .a_i(a), .b_i(b), .func_i(fn), .result_o(res), .illegal_o(ill)
  );

  function automatic logic [64:0] model(logic [63:0] x, logic [63:0] y, logic [6:0] f);
    logic [63:0] r = 64'd0;
    logic        il = 1'b0;
    case (f)
      7'h00: r = x & y;
      7'h08: r = x & ~y;
      7'h20: r = x | y;
      7'h28: r = x | ~y;
      7'h40: r = x ^ y;
      7'h48: r = ~(x ^ y);
      7'h30, 7'h31:
        for (int i = 0; i < 8; i++)
          if (y[i] != (f == 7'h31)) r[i*8 +: 8] = x[i*8 +: 8];
      default: il = 1'b1;
    endcase
    return {il, r};
  endfunction

  task automatic compare(string req);
    logic [64:0] exp = model(a, b, fn);
    total++;
    if ({ill, res} !== exp) begin
      bad++;
      $display("FAIL %s fn=%h a=%h b=%h actual=%b/%h expected=%b/%h",
               req, fn, a, b, ill, res, exp[64], exp[63:0]);
    end
  endtask

  task automatic check(string req, logic [63:0] x, logic [63:0] y, logic [6:0] f);
    @(posedge clk); #1;
    a = x; b = y; fn = f;
    @(negedge clk);
    compare(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb, r_lo;
    a = '0; b = '0; fn = '0;
    repeat (3) @(posedge clk);
    #1 compare("reset_R1");
    rst_ni = 1'b1;

    check("R1", 64'hF0F0_1234_FFFF_0000, 64'hFF00_FF00_0F0F_FFFF, 7'h00);
    check("R2", 64'hF0F0_1234_FFFF_0000, 64'hFF00_FF00_0F0F_FFFF, 7'h08);
    check("R3", 64'h0000_0000_0000_00A5, 64'h5A00_0000_0000_0000, 7'h20);
    check("R3", 64'h0000_0000_0000_00A5, 64'hFFFF_FFFF_FFFF_FF00, 7'h28);
    check("R4", 64'hAAAA_5555_0000_FFFF, 64'hFFFF_FFFF_0000_0000, 7'h40);
    check("R4", 64'hAAAA_5555_0000_FFFF, 64'hFFFF_FFFF_0000_0000, 7'h48);
    check("R5", 64'h0123_4567_89AB_CDEF, 64'h55, 7'h30);
    check("R5", 64'h0123_4567_89AB_CDEF, 64'h01, 7'h30);
    check("R5", 64'h0123_4567_89AB_CDEF, 64'hFF, 7'h30);
    check("R5", 64'h0123_4567_89AB_CDEF, 64'h00, 7'h30);
    check("R6", 64'h0123_4567_89AB_CDEF, 64'h55, 7'h31);
    check("R6", 64'h0123_4567_89AB_CDEF, 64'h80, 7'h31);
    check("R6", 64'h0123_4567_89AB_CDEF, 64'hFF, 7'h31);

    for (int k = 0; k < 40; k++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      r_lo = {56'd0, rb[7:0]};
      check("R7", ra, rb, (k % 2 == 0) ? 7'h30 : 7'h31);
      check("R7", ra, r_lo, (k % 2 == 0) ? 7'h30 : 7'h31);
    end

    for (int f = 0; f < 128; f++)
      check("R8", {$urandom, $urandom}, {$urandom, $urandom}, 7'(f));

    for (int k = 0; k < 30; k++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      check("R1", ra, rb, 7'h00);
      check("R2", ra, rb, 7'h08);
      check("R3", ra, rb, 7'h28);
      check("R4", ra, rb, 7'h48);
    end

    // R9: change inputs between edges, sample with no clock edge in between
    @(negedge clk); #0.5;
    a = 64'hDEAD_BEEF_CAFE_F00D; b = 64'h0F; fn = 7'h30;
    #0.5 compare("R9");
    b = 64'hF0;
    #0.5 compare("R9");
    fn = 7'h7F;
    #0.5 compare("R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule